// File: doc/BRIEF.md
# Serial NAND Page Read Engine

This block fetches an arbitrary run of bytes from a serial NAND flash device over a single-lane SPI link. The host hands over a byte start address and a byte count through a request/acknowledge handshake. The engine splits the request into per-page chunks. For each chunk it asks the device to move the array page into the device's internal cache and polls the status feature until the device is idle. It then reads the status feature once more to obtain the on-die ECC verdict and, if the page is usable, clocks the wanted cache bytes out of the device. Every byte is presented to the host on a byte output qualified by a one-cycle valid strobe.

The engine generates the SPI clock itself in clock mode 0: the clock idles low, data goes out most significant bit first, and the clock runs at the system clock divided by twice `SCK_HALF`. Before the first page it waits until the device reports idle. Between consecutive busy polls it keeps chip select high for a host-programmable number of system clocks. On completion it pulses `done` and reports the number of bytes delivered, together with an error flag. A count below the requested length means the request stopped on an uncorrectable page.

Top module: `nand_page_reader`

## Requirements
- R1: While reset is held and after its release, `spi_cs_n` is 1, `spi_sck` is 0, and `req_ack`, `rd_valid` and `done` are 0.
- R2: The link runs in clock mode 0: `spi_sck` is 0 whenever `spi_cs_n` is 1, `spi_mosi` is stable while `spi_sck` is high, and each byte is shifted most significant bit first in both directions.
- R3: Before the first page load, the engine sends status-poll frames (opcode 0x0F, feature address 0xC0, then one byte clocked in) and repeats them while bit 0 of the returned byte is 1. No load frame is sent until a poll has returned bit 0 = 0.
- R4: Between a poll frame that returned bit 0 = 1 and the next frame, `spi_cs_n` stays high for at least `poll_gap` system clocks.
- R5: A page load frame is opcode 0x13 followed by three row bytes, high byte first, with no dummy byte. The row is the byte address shifted right by `PAGE_BITS` (default 11, i.e. 2048-byte pages).
- R6: After each load, poll frames repeat until bit 0 of the status is 0. Exactly one further status frame follows before any cache read.
- R7: If bits [5:4] of that further status byte are 2'b10, no cache read is issued for the page. The request ends with `done_err` = 1 and `done_count` equal to the bytes already delivered. The values 2'b00, 2'b01 and 2'b11 let the read proceed.
- R8: A cache read frame is opcode 0x03, the column high byte, the column low byte and one dummy byte, where the column is the low `PAGE_BITS` bits of the address. It is followed by the chunk's data bytes. Each data byte appears on `rd_data` with `rd_valid` high for one cycle, in ascending address order.
- R9: Each chunk holds the smaller of the remaining count and the bytes left to the end of the current page. A request that crosses a page boundary continues with a new load at column 0 of the next page.
- R10: On success, `done` pulses for one cycle with `done_err` = 0 and `done_count` equal to the requested length.
- R11: A request of length 0 completes with `done_count` = 0 and `done_err` = 0, and it never drives `spi_cs_n` low.
- R12: `req_ack` is a one-cycle pulse issued only for a request that is seen while the engine is idle. One accepted request gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_ack | output | 1 | One-cycle acceptance pulse |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte count |
| poll_gap | input | GAP_W | Idle clocks between busy polls |
| busy | output | 1 | Engine is handling a request |
| rd_valid | output | 1 | `rd_data` holds a delivered byte |
| rd_data | output | 8 | Delivered data byte |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | LEN_W | Bytes delivered for the request |
| done_err | output | 1 | Request stopped on an uncorrectable page |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with `PAGE_BITS` = 6, giving 64-byte pages. Page crossings, a three-page request that fails on its last page, and a chunk ending on the final column therefore take a few hundred bytes instead of many kilobytes. `SCK_HALF` = 2 keeps each SPI bit four system clocks long. A 24-bit address and a 12-bit length keep the values small. The poll gap is set to 9, well above the fixed chip-select gap of 2, so a dropped programmable gap shows up as a short high time on chip select.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP,
    ST_FIN
  } rd_state_e;

  typedef enum logic [2:0] {
    PH_READY0,
    PH_LOAD,
    PH_BUSY,
    PH_ECC,
    PH_READ
  } rd_phase_e;

  localparam logic [7:0] OP_GET_FEAT = 8'h0F;
  localparam logic [7:0] FEAT_STATUS = 8'hC0;
  localparam logic [7:0] OP_LOAD     = 8'h13;
  localparam logic [7:0] OP_CACHE_RD = 8'h03;

  localparam int          BIT_BUSY = 0;
  localparam int          ECC_LO   = 4;
  localparam int          ECC_HI   = 5;
  localparam logic [1:0]  ECC_FAIL = 2'b10;

endpackage

// File: rtl/nand_rd_shifter.sv
module nand_rd_shifter #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       active,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);

  localparam int CNT_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(SCK_HALF - 1);

  logic             active_q, active_d;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    div_d    = div_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    rx_d     = rx_q;
    sck_d    = sck_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        sh_d     = tx;
        bit_d    = 3'd0;
        phase_d  = 1'b0;
        div_d    = '0;
        sck_d    = 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      if (!phase_q) begin
        sck_d   = 1'b1;
        phase_d = 1'b1;
        rx_d    = {rx_q[6:0], miso};
      end else begin
        sck_d   = 1'b0;
        phase_d = 1'b0;
        if (bit_q == 3'd7) begin
          active_d = 1'b0;
          done_d   = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      div_q    <= '0;
      bit_q    <= 3'd0;
      sh_q     <= 8'h00;
      rx_q     <= 8'h00;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      rx_q     <= rx_d;
      sck_q    <= sck_d;
      done_q   <= done_d;
    end
  end

  assign active = active_q;
  assign done   = done_q;
  assign rx     = rx_q;
  assign sck    = sck_q;
  assign mosi   = sh_q[7];

endmodule

// File: rtl/nand_rd_span.sv
module nand_rd_span #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [23:0]       row,
  output logic [15:0]       col,
  output logic [LEN_W-1:0]  chunk
);

  localparam int ROOM_W = PAGE_BITS + 1;
  localparam int CMP_W  = (LEN_W > ROOM_W) ? LEN_W : ROOM_W;
  localparam logic [ROOM_W-1:0] PAGE_SIZE = ROOM_W'(1) << PAGE_BITS;

  logic [ROOM_W-1:0] room;
  logic [CMP_W-1:0]  room_x;
  logic [CMP_W-1:0]  rem_x;

  always_comb begin
    room   = PAGE_SIZE - {1'b0, addr[PAGE_BITS-1:0]};
    room_x = CMP_W'(room);
    rem_x  = CMP_W'(remain);
    chunk  = (rem_x < room_x) ? remain : LEN_W'(room_x);
    row    = 24'(addr >> PAGE_BITS);
    col    = 16'(addr[PAGE_BITS-1:0]);
  end

endmodule

// File: rtl/nand_rd_gap.sv
module nand_rd_gap #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             idle
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)
      cnt_d = len;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 11,
  parameter int SCK_HALF  = 2,
  parameter int GAP_W     = 8,
  parameter int CS_GAP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ack,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              busy,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic [LEN_W-1:0]  done_count,
  output logic              done_err,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int IDX_W = PAGE_BITS + 2;
  localparam int GW    = GAP_W + 1;
  localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(4);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  rd_state_e         state_q, state_d;
  rd_phase_e         phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              issue_q, issue_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic              ack_q, ack_d;
  logic              done_q, done_d;
  logic              rdv_q, rdv_d;
  logic [7:0]        rdd_q, rdd_d;
  logic              csn_q, csn_d;

  logic              gap_load;
  logic [GW-1:0]     gap_len;
  logic              gap_idle;

  logic              eng_active;
  logic              eng_done;
  logic [7:0]        eng_rx;
  logic [7:0]        tx_byte;
  logic [IDX_W-1:0]  last_idx;

  logic [23:0]       row;
  logic [15:0]       col;
  logic [LEN_W-1:0]  chunk;

  nand_rd_span #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_span (
    .addr  (addr_q),
    .remain(remain_q),
    .row   (row),
    .col   (col),
    .chunk (chunk)
  );

  nand_rd_shifter #(
    .SCK_HALF(SCK_HALF)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (issue_q & ~eng_active),
    .tx    (tx_byte),
    .active(eng_active),
    .done  (eng_done),
    .rx    (eng_rx),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .miso  (spi_miso)
  );

  nand_rd_gap #(
    .CNT_W(GW)
  ) u_gap (
    .clk  (clk),
    .rst_n(rst_core_n),
    .load (gap_load),
    .len  (gap_len),
    .idle (gap_idle)
  );

  // byte to send and frame length for the current phase
  always_comb begin
    tx_byte  = 8'h00;
    last_idx = IDX_W'(2);
    unique case (phase_q)
      PH_LOAD: begin
        last_idx = IDX_W'(3);
        if (idx_q == IDX_W'(0))      tx_byte = OP_LOAD;
        else if (idx_q == IDX_W'(1)) tx_byte = row[23:16];
        else if (idx_q == IDX_W'(2)) tx_byte = row[15:8];
        else                         tx_byte = row[7:0];
      end
      PH_READ: begin
        last_idx = IDX_W'(3) + IDX_W'(chunk);
        if (idx_q == IDX_W'(0))      tx_byte = OP_CACHE_RD;
        else if (idx_q == IDX_W'(1)) tx_byte = col[15:8];
        else if (idx_q == IDX_W'(2)) tx_byte = col[7:0];
        else                         tx_byte = 8'h00;
      end
      default: begin
        if (idx_q == IDX_W'(0))      tx_byte = OP_GET_FEAT;
        else if (idx_q == IDX_W'(1)) tx_byte = FEAT_STATUS;
        else                         tx_byte = 8'h00;
      end
    endcase
  end

  // sequencer next state
  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    idx_d    = idx_q;
    issue_d  = 1'b0;
    addr_d   = addr_q;
    remain_d = remain_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    ack_d    = 1'b0;
    done_d   = 1'b0;
    rdv_d    = 1'b0;
    rdd_d    = rdd_q;
    csn_d    = csn_q;
    gap_load = 1'b0;
    gap_len  = GW'(CS_GAP);
    unique case (state_q)
      ST_IDLE: begin
        csn_d = 1'b1;
        if (req_valid) begin
          ack_d    = 1'b1;
          addr_d   = req_addr;
          remain_d = req_len;
          cnt_d    = '0;
          err_d    = 1'b0;
          if (req_len == '0) begin
            state_d = ST_FIN;
          end else begin
            state_d = ST_XFER;
            phase_d = PH_READY0;
            idx_d   = '0;
            issue_d = 1'b1;
            csn_d   = 1'b0;
          end
        end
      end
      ST_XFER: begin
        if (eng_done) begin
          if (phase_q == PH_READ && idx_q >= FIRST_DATA) begin
            rdv_d = 1'b1;
            rdd_d = eng_rx;
            cnt_d = cnt_q + 1'b1;
          end
          if (idx_q == last_idx) begin
            csn_d    = 1'b1;
            state_d  = ST_GAP;
            gap_load = 1'b1;
            unique case (phase_q)
              PH_READY0, PH_BUSY: begin
                if (eng_rx[BIT_BUSY])
                  gap_len = GW'(CS_GAP) + GW'(poll_gap);
                else
                  phase_d = (phase_q == PH_READY0) ? PH_LOAD : PH_ECC;
              end
              PH_LOAD: phase_d = PH_BUSY;
              PH_ECC: begin
                if (eng_rx[ECC_HI:ECC_LO] == ECC_FAIL) begin
                  state_d  = ST_FIN;
                  err_d    = 1'b1;
                  gap_load = 1'b0;
                end else begin
                  phase_d = PH_READ;
                end
              end
              default: begin
                addr_d   = addr_q + ADDR_W'(chunk);
                remain_d = remain_q - chunk;
                if (remain_q == chunk) begin
                  state_d  = ST_FIN;
                  gap_load = 1'b0;
                end else begin
                  phase_d = PH_LOAD;
                end
              end
            endcase
          end else begin
            idx_d   = idx_q + 1'b1;
            issue_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gap_idle) begin
          state_d = ST_XFER;
          idx_d   = '0;
          issue_d = 1'b1;
          csn_d   = 1'b0;
        end
      end
      default: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_READY0;
      idx_q    <= '0;
      issue_q  <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
      rdv_q    <= 1'b0;
      rdd_q    <= 8'h00;
      csn_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      issue_q  <= issue_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
      ack_q    <= ack_d;
      done_q   <= done_d;
      rdv_q    <= rdv_d;
      rdd_q    <= rdd_d;
      csn_q    <= csn_d;
    end
  end

  assign req_ack    = ack_q;
  assign busy       = (state_q != ST_IDLE);
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign done       = done_q;
  assign done_count = cnt_q;
  assign done_err   = err_q;
  assign spi_cs_n   = csn_q;

endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LEN_W-1:0] req_len,
  input logic             req_ack,
  input logic             busy,
  input logic             done,
  input logic             done_err,
  input logic [LEN_W-1:0] done_count,
  input logic             rd_valid,
  input logic             spi_cs_n,
  input logic             spi_sck,
  input logic             spi_mosi
);

  logic [LEN_W-1:0] asked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      asked_q <= '0;
    else if (req_valid && !busy)
      asked_q <= req_len;
  end

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R2

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R2

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R12

  AST_ACK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> ($past(req_valid) && !$past(busy))); // R12

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_count == asked_q)); // R10

  AST_SHORT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> (done_count < asked_q)); // R7

  AST_DATA_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy); // R8

  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n); // R11

endmodule

bind nand_page_reader nand_page_reader_chk #(
  .LEN_W(LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_len   (req_len),
  .req_ack   (req_ack),
  .busy      (busy),
  .done      (done),
  .done_err  (done_err),
  .done_count(done_count),
  .rd_valid  (rd_valid),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi)
);

// File: tb/nand_page_reader_test.sv
`timescale 1ns/1ps
module nand_page_reader_test;

  localparam int AW  = 24;
  localparam int LW  = 12;
  localparam int PB  = 6;
  localparam int GPW = 6;
  localparam int PG  = 1 << PB;
  localparam int GAP_CFG = 9;

  typedef struct packed {
    logic [23:0] addr;
    logic [11:0] len;
    logic [3:0]  busy;
    logic [11:0] bad;
    logic [11:0] cnt;
    logic        err;
    logic [3:0]  loads;
  } vec_t;

  // bad = page number whose status reports 2'b10; 12'hFFF means none
  localparam vec_t VECS [6] = '{
    '{24'h000010, 12'd8,   4'd0, 12'hFFF, 12'd8,   1'b0, 4'd1},
    '{24'h00003C, 12'd10,  4'd2, 12'hFFF, 12'd10,  1'b0, 4'd2},
    '{24'h0000F0, 12'd100, 4'd1, 12'd5,   12'd80,  1'b1, 4'd3},
    '{24'h000200, 12'd5,   4'd0, 12'd8,   12'd0,   1'b1, 4'd1},
    '{24'h00007F, 12'd1,   4'd3, 12'hFFF, 12'd1,   1'b0, 4'd1},
    '{24'h000040, 12'd64,  4'd1, 12'hFFF, 12'd64,  1'b0, 4'd1}
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ack;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [GPW-1:0] poll_gap;
  logic          busy;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          done;
  logic [LW-1:0] done_count;
  logic          done_err;
  logic          spi_cs_n;
  logic          spi_sck;
  logic          spi_mosi;
  logic          spi_miso;

  nand_page_reader #(
    .ADDR_W   (AW),
    .LEN_W    (LW),
    .PAGE_BITS(PB),
    .SCK_HALF (2),
    .GAP_W    (GPW),
    .CS_GAP   (2)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .poll_gap  (poll_gap),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .done      (done),
    .done_count(done_count),
    .done_err  (done_err),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit wd     = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input logic [23:0] pg, input logic [15:0] c);
    logic [7:0] p8;
    p8 = pg[7:0];
    return c[7:0] + (p8 * 8'd37) + 8'h5A;
  endfunction

  // ---------------- flash device model ----------------
  int          m_bits, m_byte;
  logic [7:0]  m_in, m_out, m_op;
  logic [23:0] m_row;
  logic [15:0] m_col;
  logic [1:0]  m_ecc;
  int          busy_left, busy_cfg;
  bit          ready_rep, last_busy;
  int          nb_frames;
  int          viol, gap_viol, loads, cs_falls, sck_bad;
  int          cs_rise_cyc;
  logic [11:0] bad_pg;

  initial begin
    spi_miso = 1'b0;
    m_bits = 0; m_byte = 0; m_out = 8'h00; m_in = 8'h00; m_op = 8'h00;
    m_row = '0; m_col = '0; m_ecc = 2'b00;
    busy_left = 0; busy_cfg = 0; ready_rep = 1'b0; last_busy = 1'b0;
    nb_frames = 0; viol = 0; gap_viol = 0; loads = 0; cs_falls = 0;
    sck_bad = 0; cs_rise_cyc = 0; bad_pg = 12'hFFF;
  end

  always @(posedge spi_cs_n) cs_rise_cyc = cyc;

  always @(negedge spi_cs_n) begin
    m_bits = 0; m_byte = 0; m_out = 8'h00; spi_miso = 1'b0;
    cs_falls++;
    if (last_busy && (cyc - cs_rise_cyc) < GAP_CFG) gap_viol++;
  end

  always @(negedge clk) if (spi_cs_n === 1'b1 && spi_sck !== 1'b0) sck_bad++;

  always @(posedge spi_sck) begin
    if (spi_cs_n === 1'b0) begin
      m_in = {m_in[6:0], spi_mosi};
      m_bits++;
      if (m_bits == 8) begin
        m_bits = 0;
        if (m_byte == 0) begin
          m_op = m_in;
          last_busy = 1'b0;
          if (m_in == 8'h13 && !ready_rep) viol++;
          if (m_in == 8'h03 && (nb_frames != 2 || m_ecc == 2'b10)) viol++;
          if (m_in != 8'h13 && m_in != 8'h03 && m_in != 8'h0F) viol++;
        end else begin
          case (m_op)
            8'h0F: begin
              if (m_byte == 1) begin
                if (m_in != 8'hC0) viol++;
                m_out = {2'b00, (busy_left == 0) ? m_ecc : 2'b00, 3'b000,
                         (busy_left != 0)};
              end else if (m_byte == 2) begin
                if (m_out[0]) begin
                  busy_left--;
                  last_busy = 1'b1;
                end else begin
                  ready_rep = 1'b1;
                  nb_frames++;
                end
              end
            end
            8'h13: begin
              if (m_byte == 1) m_row[23:16] = m_in;
              else if (m_byte == 2) m_row[15:8] = m_in;
              else if (m_byte == 3) begin
                m_row[7:0] = m_in;
                loads++;
                busy_left = busy_cfg;
                ready_rep = 1'b0;
                nb_frames = 0;
                if (m_row[11:0] == bad_pg) m_ecc = 2'b10;
                else m_ecc = m_row[0] ? 2'b01 : 2'b11;
              end
            end
            8'h03: begin
              if (m_byte == 1) m_col[15:8] = m_in;
              else if (m_byte == 2) m_col[7:0] = m_in;
              else if (m_byte == 3) m_out = dat(m_row, m_col);
              else begin
                m_col = m_col + 16'd1;
                m_out = dat(m_row, m_col);
              end
            end
            default: ;
          endcase
        end
        m_byte++;
      end
    end
  end

  always @(negedge spi_sck) begin
    if (spi_cs_n === 1'b0) spi_miso = m_out[7 - m_bits];
  end

  // ---------------- host-side monitors ----------------
  int          ack_cnt = 0;
  int          got = 0;
  int          mism = 0;
  logic [23:0] exp_a = '0;

  always @(negedge clk) begin
    if (req_ack === 1'b1) ack_cnt++;
    if (rd_valid === 1'b1) begin
      got++;
      if (rd_data !== dat(24'(exp_a >> PB), 16'(exp_a & (PG - 1)))) mism++;
      exp_a = exp_a + 24'd1;
    end
  end

  int res_cnt, res_err;

  task automatic do_req(input logic [23:0] a, input logic [11:0] l);
    @(negedge clk);
    req_addr  = a;
    req_len   = l;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ack && !wd);
    req_valid = 1'b0;
    while (!done && !wd) @(negedge clk);
    res_cnt = done_count;
    res_err = done_err;
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    poll_gap  = GPW'(GAP_CFG);
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check(spi_cs_n === 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
    check(spi_sck === 1'b0, "R1", "sck in reset", spi_sck, 0);
    check(rd_valid === 1'b0 && done === 1'b0, "R1", "valid/done in reset",
          rd_valid | done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ack === 1'b0 && spi_cs_n === 1'b1, "R1", "idle after release",
          req_ack, 0);

    // R11: zero-length request
    begin
      int falls0;
      falls0  = cs_falls;
      ack_cnt = 0;
      do_req(24'h000123, 12'd0);
      check(res_cnt == 0, "R11", "zero-length count", res_cnt, 0);
      check(res_err == 0, "R11", "zero-length err", res_err, 0);
      check(cs_falls == falls0, "R11", "zero-length cs activity", cs_falls - falls0, 0);
      @(negedge clk);
      check(ack_cnt == 1, "R12", "ack pulses for zero-length", ack_cnt, 1);
    end

    // table walk
    for (int i = 0; i < 6; i++) begin
      int loads0;
      busy_cfg  = VECS[i].busy;
      busy_left = VECS[i].busy;
      ready_rep = 1'b0;
      nb_frames = 0;
      m_ecc     = 2'b00;
      bad_pg    = VECS[i].bad;
      viol      = 0;
      gap_viol  = 0;
      got       = 0;
      mism      = 0;
      ack_cnt   = 0;
      exp_a     = VECS[i].addr;
      loads0    = loads;
      do_req(VECS[i].addr, VECS[i].len);
      @(negedge clk);
      check(res_cnt == VECS[i].cnt, VECS[i].err ? "R7" : "R10", "done_count",
            res_cnt, VECS[i].cnt);
      check(res_err == VECS[i].err, VECS[i].err ? "R7" : "R10", "done_err",
            res_err, VECS[i].err);
      check(got == VECS[i].cnt, "R8", "bytes strobed", got, VECS[i].cnt);
      check(mism == 0, "R5/R8", "data byte mismatches", mism, 0);
      check(viol == 0, "R3/R6", "frame order violations", viol, 0);
      check(gap_viol == 0, "R4", "short poll gaps", gap_viol, 0);
      check(loads - loads0 == VECS[i].loads, "R9", "page loads", loads - loads0,
            VECS[i].loads);
      check(ack_cnt == 1, "R12", "ack pulses", ack_cnt, 1);
    end

    // R2: clock idle low whenever deselected, across the whole run
    check(sck_bad == 0, "R2", "sck high while deselected", sck_bad, 0);

    if (wd) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (wd);
    repeat (2) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule